// File: doc/BRIEF.md
# Merged Activity-Change Interrupt Controller

This block collects activity flags from a set of detector channels and folds every change of any enabled channel into one shared interrupt source. That single source drives two interrupt pins at once. Each pin has its own mode bit, so one pin can emit a one-cycle pulse per event while the other holds a level until software has dealt with the cause.

Software locates the cause through a small read port. There is one value register per channel, holding the activity flag captured at that channel's latest event. There are also two pairs of sticky status registers: one pair records rising changes and the other records falling changes, each pair split into a low and a high half of the channel vector. Reading a status register returns its bits and clears them. The pending interrupt is held for as long as any status bit remains set. An event that lands in the same cycle as a clearing read is kept.

Top module: `act_irq_merge`

## Requirements
- R1: After reset both irq_o bits are 0, every value register and status register reads 0, and rd_data_o is 0.
- R2: A channel produces an event in a cycle when its chan_en_i bit is 1 and its act_i bit differs from the act_i bit sampled in the previous cycle (0 right after reset). Changes on a disabled channel produce no event and leave its value register unchanged.
- R3: Both pins are driven from one shared source. An event on any channel affects both pins, and pins set to the same mode are always equal.
- R4: With irq_mode_i[p] = 0 (pulse), irq_o[p] is 1 for exactly the cycle after each cycle that contains at least one event, and 0 otherwise.
- R5: With irq_mode_i[p] = 1 (level), irq_o[p] is 1 in the cycle after any status bit becomes set, and stays 1 until the edge at which the last status bit is cleared.
- R6: A read of address c (0 to NCH-1) returns in bit 0 the act_i value of channel c captured at its most recent event, with all other bits 0. Reading it clears nothing.
- R7: Status addresses: 0x10 holds the rising flags of channels 0-7, 0x11 the rising flags of channels 8-15, 0x12 the falling flags of channels 0-7, and 0x13 the falling flags of channels 8-15. Bit i of each register is the channel at offset i within its half.
- R8: A read of a status address returns that register's flags as they stood before the read, and clears exactly those bits.
- R9: When an event arrives in the same cycle as a read that clears its flag, the flag stays set and the interrupt remains pending.
- R10: Read data appears on rd_data_o in the cycle after rd_en_i and holds until the next read. Unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_i | input | NCH | Per-channel activity flags from the detectors |
| chan_en_i | input | NCH | Per-channel event enable |
| irq_mode_i | input | 2 | Per-pin mode: 0 pulse, 1 level |
| rd_en_i | input | 1 | Single-cycle read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | REG_W | Registered read data |
| irq_o | output | 2 | Interrupt pins |

## Verification
The checker assumes that act_i, chan_en_i and the read strobe change only between clock edges. It also assumes that a pin's mode bit is held over the cycle whose event or flag state that pin reflects. The pulse and level properties therefore key on the mode sampled one cycle earlier. Stimulus is driven on the falling edge. Mode bits, enables, activity and reads are drawn at random, with reads dense enough that clearing reads often collide with fresh events. Directed cases cover the collision, disabled channels and the high half of the status map.

// File: rtl/act_irq_pkg.sv
package act_irq_pkg;
  // Offsets of the status registers relative to the status base
  typedef enum logic [1:0] {
    ST_RISE_LO = 2'd0,
    ST_RISE_HI = 2'd1,
    ST_FALL_LO = 2'd2,
    ST_FALL_HI = 2'd3
  } stat_sel_e;

  localparam int unsigned PIN_N = 2;
endpackage

// File: rtl/act_irq_edge.sv
module act_irq_edge #(
  parameter int unsigned NCH = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] act_i,
  input  logic [NCH-1:0] en_i,
  output logic [NCH-1:0] rise_o,
  output logic [NCH-1:0] fall_o,
  output logic [NCH-1:0] val_o
);
  logic [NCH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= act_i;
  end

  assign rise_o = en_i &  act_i & ~prev_q;
  assign fall_o = en_i & ~act_i &  prev_q;

  // One capture register per channel, loaded only on that channel's event
  for (genvar ch = 0; ch < NCH; ch++) begin : g_val
    logic cap_q;
    always_ff @(posedge clk) begin
      if (rst)                          cap_q <= 1'b0;
      else if (rise_o[ch] | fall_o[ch]) cap_q <= act_i[ch];
    end
    assign val_o[ch] = cap_q;
  end
endmodule

// File: rtl/act_irq_flags.sv
module act_irq_flags #(
  parameter int unsigned NCH = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] rise_i,
  input  logic [NCH-1:0] fall_i,
  input  logic [NCH-1:0] clr_rise_i,
  input  logic [NCH-1:0] clr_fall_i,
  output logic [NCH-1:0] rise_q,
  output logic [NCH-1:0] fall_q,
  output logic           pend_nx_o
);
  logic [NCH-1:0] rise_nx, fall_nx;

  // A new event outranks a clear in the same cycle
  assign rise_nx   = (rise_q & ~clr_rise_i) | rise_i;
  assign fall_nx   = (fall_q & ~clr_fall_i) | fall_i;
  assign pend_nx_o = |{rise_nx, fall_nx};

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      rise_q <= rise_nx;
      fall_q <= fall_nx;
    end
  end
endmodule

// File: rtl/act_irq_rdport.sv
module act_irq_rdport
  import act_irq_pkg::*;
#(
  parameter int unsigned    NCH       = 12,
  parameter int unsigned    REG_W     = 8,
  parameter int unsigned    ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] STAT_BASE = 'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [NCH-1:0]    val_i,
  input  logic [NCH-1:0]    rise_i,
  input  logic [NCH-1:0]    fall_i,
  output logic [NCH-1:0]    clr_rise_o,
  output logic [NCH-1:0]    clr_fall_o,
  output logic [REG_W-1:0]  rd_data_o
);
  localparam int unsigned EXT_W = 2 * REG_W;

  logic [EXT_W-1:0] rise_ext, fall_ext;
  logic [REG_W-1:0] rd_nx;

  always_comb begin
    rise_ext = '0;
    fall_ext = '0;
    rise_ext[NCH-1:0] = rise_i;
    fall_ext[NCH-1:0] = fall_i;
  end

  // Each channel's flag clears on a read of the half that holds it
  for (genvar ch = 0; ch < NCH; ch++) begin : g_clr
    localparam logic [ADDR_W-1:0] RISE_A =
      STAT_BASE + ADDR_W'(ST_RISE_LO) + ADDR_W'(ch / REG_W);
    localparam logic [ADDR_W-1:0] FALL_A =
      STAT_BASE + ADDR_W'(ST_FALL_LO) + ADDR_W'(ch / REG_W);
    assign clr_rise_o[ch] = rd_en_i && (rd_addr_i == RISE_A);
    assign clr_fall_o[ch] = rd_en_i && (rd_addr_i == FALL_A);
  end

  always_comb begin
    rd_nx = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      if (rd_addr_i == ADDR_W'(ch)) rd_nx[0] = val_i[ch];
    end
    if (rd_addr_i == STAT_BASE + ADDR_W'(ST_RISE_LO)) rd_nx = rise_ext[REG_W-1:0];
    if (rd_addr_i == STAT_BASE + ADDR_W'(ST_RISE_HI)) rd_nx = rise_ext[EXT_W-1:REG_W];
    if (rd_addr_i == STAT_BASE + ADDR_W'(ST_FALL_LO)) rd_nx = fall_ext[REG_W-1:0];
    if (rd_addr_i == STAT_BASE + ADDR_W'(ST_FALL_HI)) rd_nx = fall_ext[EXT_W-1:REG_W];
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_nx;
  end
endmodule

// File: rtl/act_irq_pins.sv
module act_irq_pins #(
  parameter int unsigned NPIN = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] mode_i,
  input  logic            evt_i,
  input  logic            pend_nx_i,
  output logic [NPIN-1:0] irq_o
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic pin_q;
    always_ff @(posedge clk) begin
      if (rst) pin_q <= 1'b0;
      else     pin_q <= mode_i[p] ? pend_nx_i : evt_i;
    end
    assign irq_o[p] = pin_q;
  end
endmodule

// File: rtl/act_irq_merge.sv
module act_irq_merge
  import act_irq_pkg::*;
#(
  parameter int unsigned       NCH       = 12,
  parameter int unsigned       REG_W     = 8,
  parameter int unsigned       ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] STAT_BASE = 'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    act_i,
  input  logic [NCH-1:0]    chan_en_i,
  input  logic [PIN_N-1:0]  irq_mode_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic [PIN_N-1:0]  irq_o
);
  logic [NCH-1:0] rise_evt, fall_evt, val_q;
  logic [NCH-1:0] rise_q, fall_q, clr_rise, clr_fall;
  logic           pend_nx;
  logic           any_evt;

  assign any_evt = |{rise_evt, fall_evt};

  act_irq_edge #(.NCH(NCH)) edge_i (
    .clk(clk), .rst(rst), .act_i(act_i), .en_i(chan_en_i),
    .rise_o(rise_evt), .fall_o(fall_evt), .val_o(val_q)
  );

  act_irq_flags #(.NCH(NCH)) flags_i (
    .clk(clk), .rst(rst), .rise_i(rise_evt), .fall_i(fall_evt),
    .clr_rise_i(clr_rise), .clr_fall_i(clr_fall),
    .rise_q(rise_q), .fall_q(fall_q), .pend_nx_o(pend_nx)
  );

  act_irq_rdport #(.NCH(NCH), .REG_W(REG_W), .ADDR_W(ADDR_W), .STAT_BASE(STAT_BASE)) rd_i (
    .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .val_i(val_q), .rise_i(rise_q), .fall_i(fall_q),
    .clr_rise_o(clr_rise), .clr_fall_o(clr_fall), .rd_data_o(rd_data_o)
  );

  act_irq_pins #(.NPIN(PIN_N)) pins_i (
    .clk(clk), .rst(rst), .mode_i(irq_mode_i), .evt_i(any_evt),
    .pend_nx_i(pend_nx), .irq_o(irq_o)
  );
endmodule

// File: rtl/act_irq_chk.sv
module act_irq_chk #(
  parameter int unsigned NCH = 12
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] act_i,
  input logic [1:0]     irq_mode_i,
  input logic [1:0]     irq_o,
  input logic [NCH-1:0] rise_evt,
  input logic [NCH-1:0] fall_evt,
  input logic [NCH-1:0] rise_q,
  input logic [NCH-1:0] fall_q,
  input logic [NCH-1:0] clr_rise,
  input logic [NCH-1:0] clr_fall,
  input logic [NCH-1:0] val_q
);
  // R3
  same_mode_pins_chk: assert property (@(posedge clk) disable iff (rst)
    $past(irq_mode_i[0] == irq_mode_i[1]) |-> (irq_o[0] == irq_o[1]));

  // R4
  pulse_has_event_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!irq_mode_i[0]) && irq_o[0]) |-> $past(|{rise_evt, fall_evt}));

  // R5
  level_tracks_flags_chk: assert property (@(posedge clk) disable iff (rst)
    $past(irq_mode_i[1]) |-> (irq_o[1] == |{rise_q, fall_q}));

  // R9
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (|((rise_evt & clr_rise) | (fall_evt & clr_fall))) |=> (|{rise_q, fall_q}));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    // R6
    val_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (rise_evt[ch] || fall_evt[ch]) |=> (val_q[ch] == $past(act_i[ch])));
    // R6
    val_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(rise_evt[ch] || fall_evt[ch]) |=> $stable(val_q[ch]));
  end
endmodule

bind act_irq_merge act_irq_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst(rst), .act_i(act_i), .irq_mode_i(irq_mode_i), .irq_o(irq_o),
  .rise_evt(rise_evt), .fall_evt(fall_evt), .rise_q(rise_q), .fall_q(fall_q),
  .clr_rise(clr_rise), .clr_fall(clr_fall), .val_q(val_q)
);

// File: tb/act_irq_merge_tb.sv
`timescale 1ns/1ps
module act_irq_merge_tb_top;
  localparam int NCH   = 12;
  localparam int REG_W = 8;
  localparam int AW    = 5;
  localparam logic [AW-1:0] SB = 5'h10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NCH-1:0]  act = '0, en = '0;
  logic [1:0]      mode = '0;
  logic            rd_en = 1'b0;
  logic [AW-1:0]   rd_addr = '0;
  logic [REG_W-1:0] rd_data;
  logic [1:0]      irq;

  int n_cmp = 0, n_bad = 0;
  logic [NCH-1:0]   m_prev, m_val, m_rise, m_fall;
  logic [REG_W-1:0] m_rd;
  logic [1:0]       m_irq;

  always #2.5 clk = ~clk;

  act_irq_merge dut_i (
    .clk(clk), .rst(rst), .act_i(act), .chan_en_i(en), .irq_mode_i(mode),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  function automatic logic [REG_W-1:0] model_read(logic [AW-1:0] a);
    logic [2*REG_W-1:0] r, f;
    r = '0; f = '0;
    r[NCH-1:0] = m_rise; f[NCH-1:0] = m_fall;
    if (a < AW'(NCH)) return {{(REG_W-1){1'b0}}, m_val[a]};
    case (a)
      SB:      return r[REG_W-1:0];
      SB + 1:  return r[2*REG_W-1:REG_W];
      SB + 2:  return f[REG_W-1:0];
      SB + 3:  return f[2*REG_W-1:REG_W];
      default: return '0;
    endcase
  endfunction

  function automatic string rd_tag(logic [AW-1:0] a);
    if (a < AW'(NCH)) return "R6";
    if (a >= SB && a <= SB + 3) return "R8";
    return "R10";
  endfunction

  task automatic check(string tag, logic [31:0] act_v, logic [31:0] exp_v);
    n_cmp++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic model_reset();
    m_prev = '0; m_val = '0; m_rise = '0; m_fall = '0; m_rd = '0; m_irq = '0;
  endtask

  // One cycle: drive at negedge, predict, sample 1 ns after posedge
  task automatic step(logic [NCH-1:0] a, logic [NCH-1:0] e, logic [1:0] md,
                      logic r, logic [AW-1:0] ad, string tag);
    logic [NCH-1:0] re, fe, cr, cf;
    @(negedge clk);
    act = a; en = e; mode = md; rd_en = r; rd_addr = ad;
    re = e & a & ~m_prev;
    fe = e & ~a & m_prev;
    for (int ch = 0; ch < NCH; ch++) begin
      cr[ch] = r && (ad == SB + AW'(ch / REG_W));
      cf[ch] = r && (ad == SB + 2 + AW'(ch / REG_W));
    end
    if (r) m_rd = model_read(ad);
    m_rise = (m_rise & ~cr) | re;
    m_fall = (m_fall & ~cf) | fe;
    for (int p = 0; p < 2; p++)
      m_irq[p] = md[p] ? |{m_rise, m_fall} : |{re, fe};
    for (int ch = 0; ch < NCH; ch++)
      if (re[ch] | fe[ch]) m_val[ch] = a[ch];
    m_prev = a;
    @(posedge clk); #1;
    check(tag != "" ? tag : "R4/R5 pin0", irq[0], m_irq[0]);
    check(tag != "" ? tag : "R3/R4/R5 pin1", irq[1], m_irq[1]);
    check(tag != "" ? tag : (r ? rd_tag(ad) : "R10 hold"), rd_data, m_rd);
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [NCH-1:0] cur;
    seed = 32'd2024;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: reset state
    check("R1 irq", irq, 0);
    check("R1 rd", rd_data, 0);
    for (int a = 0; a < NCH; a++) step('0, '0, 2'b00, 1'b1, AW'(a), "R1");
    for (int a = 0; a < 4; a++) step('0, '0, 2'b00, 1'b1, SB + AW'(a), "R1");

    // R2: disabled channel toggles leave no trace
    step(12'h001, 12'hFFE, 2'b11, 1'b0, '0, "R2");
    step(12'h000, 12'hFFE, 2'b11, 1'b1, 5'd0, "R2");
    step(12'h000, 12'hFFE, 2'b11, 1'b1, SB, "R2");

    // R7/R5: channel 9 rising in level mode on both pins, read the high half
    step(12'h200, 12'hFFF, 2'b11, 1'b0, '0, "R7 level set");
    step(12'h200, 12'hFFF, 2'b11, 1'b0, '0, "R5 hold");
    step(12'h200, 12'hFFF, 2'b11, 1'b1, SB + 1, "R7 rise hi");
    step(12'h200, 12'hFFF, 2'b11, 1'b1, SB + 1, "R8 cleared");
    step(12'h200, 12'hFFF, 2'b11, 1'b1, 5'd9, "R6 val ch9");

    // R9: falling event on ch9 lands with the clearing read of fall high
    step(12'h000, 12'hFFF, 2'b01, 1'b1, SB + 3, "R9 collide");
    step(12'h000, 12'hFFF, 2'b01, 1'b1, SB + 3, "R9 kept");
    step(12'h000, 12'hFFF, 2'b01, 1'b0, '0, "R9 after");

    // R10: unmapped address
    step(12'h000, 12'hFFF, 2'b00, 1'b1, 5'h1F, "R10 unmapped");

    // R3/R4/R5 random mix
    cur = '0;
    for (int i = 0; i < 4000; i++) begin
      logic [NCH-1:0] flip, e;
      logic [1:0] md;
      logic r;
      logic [AW-1:0] ad;
      flip = (($urandom % 4) == 0) ? NCH'(1 << ($urandom % NCH)) : '0;
      if (($urandom % 16) == 0) flip = NCH'($urandom);
      cur ^= flip;
      e  = (($urandom % 8) == 0) ? NCH'($urandom) : 12'hFFF;
      md = (($urandom % 32) == 0) ? 2'($urandom) : mode;
      r  = ($urandom % 3) == 0;
      ad = (($urandom % 3) == 0) ? AW'($urandom % NCH) : SB + AW'($urandom % 5);
      step(cur, e, md, r, ad, "");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule